// File: doc/BRIEF.md
# Word Shifter with Saturating Count

This block shifts a data word left or right, logically or arithmetically, in a single combinational pass. An optional register stage can follow the shifter. The caller chooses the shift kind and supplies a data operand. The shift count comes either from the low bits of a second register operand or from a short immediate field.

Register-sourced counts saturate. When the top bit of the count field is set, the amount becomes exactly one full word. The word then clears for logical shifts and fills with the sign for arithmetic shifts.

Next to the shifted word, the block computes a carry flag that records lost 1-bits of negative operands on arithmetic right shifts. When recording is requested, it also produces a 4-bit condition field that compares the result with zero as a signed value.

The word width `W` defaults to 32. The register count field is `log2(W)+1` bits wide (6 bits for 32). The immediate count is `log2(W)` bits wide (5 bits for 32).

Top module: `word_shifter`

## Requirements
- R1: With `kind`=00 the result is `srcA` shifted toward the most significant end by the amount, with zeros entering at the least significant end.
- R2: With `kind`=01 the result is `srcA` shifted toward the least significant end by the amount, with zeros entering at the most significant end.
- R3: With `kind`=10 or 11 the result is `srcA` shifted toward the least significant end by the amount, with copies of the sign bit `srcA[W-1]` entering.
- R4: When `useImm`=0 the amount is taken from `srcB[log2(W):0]` only, and every higher bit of `srcB` has no effect on any output.
- R5: When `useImm`=0 and `srcB[log2(W)]` is 1, the amount is exactly W. Logical kinds then give an all-zero result, and arithmetic kinds give W copies of the sign bit.
- R6: When `useImm`=1 the amount is `immCnt` (0 to W-1), and `srcB` has no effect on any output.
- R7: For arithmetic kinds, `carryOut` is 1 exactly when `srcA` is negative and at least one 1-bit was shifted out at the least significant end; otherwise it is 0.
- R8: For logical kinds, `carryOut` equals `carryIn`.
- R9: An amount of zero returns `srcA` unchanged, and for arithmetic kinds it gives `carryOut`=0.
- R10: `crValid` equals `record` of the accepted input. When recording, `crOut` is {LT, GT, EQ, SO} in bits 3 down to 0. LT, GT and EQ compare the result as a signed value with zero, so exactly one of them is set, and SO copies `soIn`. When not recording, `crOut` is 0.
- R11: With `OUT_REG`=1 all outputs appear one clock after the inputs, and reset (`rstN` low) forces `outValid`, `result`, `carryOut`, `crValid` and `crOut` to 0. With `OUT_REG`=0 the outputs follow the inputs in the same cycle and `outValid` equals `inValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands are valid this cycle |
| kind | input | 2 | 00 left logical, 01 right logical, 1x right arithmetic |
| useImm | input | 1 | 1 selects the immediate count, 0 the register count |
| srcA | input | W | Word to shift |
| srcB | input | W | Register operand carrying the count in its low bits |
| immCnt | input | log2(W) | Immediate count |
| record | input | 1 | Request the condition field |
| soIn | input | 1 | Summary-overflow bit copied into the condition field |
| carryIn | input | 1 | Current carry, passed through by logical kinds |
| outValid | output | 1 | Outputs are valid |
| result | output | W | Shifted word |
| carryOut | output | 1 | Updated carry flag |
| crValid | output | 1 | Condition field is being written |
| crOut | output | 4 | {LT, GT, EQ, SO} |

## Verification
The bench builds the block with `W`=8 and `OUT_REG`=1. This makes the register count field 4 bits wide and the immediate 3 bits wide. Every operand value can then be combined with every count field value, including the saturating counts 8 to 15, for all four kind codes.

Immediate counts are swept over every operand with garbage in `srcB`. This reaches the ignored-bit rules, the one-cycle latency and the carry and condition rules for all sign and lost-bit combinations.

// File: rtl/wshift_pkg.sv
package wshift_pkg;

  typedef enum logic [1:0] {
    KIND_SLL  = 2'b00,
    KIND_SRL  = 2'b01,
    KIND_SRA  = 2'b10,
    KIND_SRAX = 2'b11
  } shiftKind_e;

  // Strobes passed from count/kind decode to the datapath
  typedef struct packed {
    logic goLeft;     // shift toward the most significant end
    logic arith;      // sign fill and carry generation
    logic keepCarry;  // pass carryIn through
    logic full;       // amount saturated to a whole word
  } shiftStrobe_t;

endpackage

// File: rtl/wshift_ctrl.sv
module wshift_ctrl
  import wshift_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]               kind,
  input  logic                     useImm,
  input  logic [W-1:0]             cntReg,
  input  logic [$clog2(W)-1:0]     cntImm,
  output shiftStrobe_t             strobe,
  output logic [$clog2(W):0]       amount
);
  localparam int IMM_W = $clog2(W);
  localparam int CNT_W = IMM_W + 1;

  logic [CNT_W-1:0] regField;
  logic             regSat;

  assign regField = cntReg[CNT_W-1:0];
  assign regSat   = regField[CNT_W-1];

  always_comb begin
    strobe.goLeft    = (kind == KIND_SLL);
    strobe.arith     = kind[1];
    strobe.keepCarry = ~kind[1];
    strobe.full      = ~useImm & regSat;
    if (useImm) begin
      amount = {1'b0, cntImm};
    end else if (regSat) begin
      amount = CNT_W'(W);
    end else begin
      amount = regField;
    end
  end

endmodule

// File: rtl/wshift_dp.sv
module wshift_dp
  import wshift_pkg::*;
#(
  parameter int W = 32
) (
  input  shiftStrobe_t         strobe,
  input  logic [$clog2(W):0]   amount,
  input  logic [W-1:0]         srcA,
  input  logic                 carryIn,
  input  logic                 record,
  input  logic                 soIn,
  output logic [W-1:0]         shiftRes,
  output logic                 carryRes,
  output logic [3:0]           crRes
);
  localparam int IMM_W = $clog2(W);

  logic [IMM_W-1:0] amt;
  logic [W-1:0]     fillWord;
  logic [W-1:0]     lostMask;
  logic [W-1:0]     leftRes;
  logic [W-1:0]     rightRes;
  logic             isNeg;
  logic             isZero;

  assign amt      = amount[IMM_W-1:0];
  assign fillWord = strobe.arith ? {W{srcA[W-1]}} : '0;

  always_comb begin
    if (strobe.full) begin
      leftRes  = '0;
      rightRes = fillWord;
      lostMask = '1;
    end else begin
      leftRes  = srcA << amt;
      rightRes = strobe.arith ? W'($signed(srcA) >>> amt) : (srcA >> amt);
      lostMask = ~({W{1'b1}} << amt);
    end
  end

  assign shiftRes = strobe.goLeft ? leftRes : rightRes;

  assign carryRes = strobe.keepCarry ? carryIn
                                     : (srcA[W-1] & (|(srcA & lostMask)));

  assign isNeg  = shiftRes[W-1];
  assign isZero = (shiftRes == '0);
  assign crRes  = record ? {isNeg, ~isNeg & ~isZero, isZero, soIn} : 4'b0000;

endmodule

// File: rtl/word_shifter.sv
module word_shifter
  import wshift_pkg::*;
#(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [1:0]             kind,
  input  logic                   useImm,
  input  logic [W-1:0]           srcA,
  input  logic [W-1:0]           srcB,
  input  logic [$clog2(W)-1:0]   immCnt,
  input  logic                   record,
  input  logic                   soIn,
  input  logic                   carryIn,
  output logic                   outValid,
  output logic [W-1:0]           result,
  output logic                   carryOut,
  output logic                   crValid,
  output logic [3:0]             crOut
);
  localparam int CNT_W = $clog2(W) + 1;

  shiftStrobe_t     strobe;
  logic [CNT_W-1:0] amount;
  logic [W-1:0]     shiftRes;
  logic             carryRes;
  logic [3:0]       crRes;

  wshift_ctrl #(.W(W)) i_ctrl (
    .kind   (kind),
    .useImm (useImm),
    .cntReg (srcB),
    .cntImm (immCnt),
    .strobe (strobe),
    .amount (amount)
  );

  wshift_dp #(.W(W)) i_dp (
    .strobe   (strobe),
    .amount   (amount),
    .srcA     (srcA),
    .carryIn  (carryIn),
    .record   (record),
    .soIn     (soIn),
    .shiftRes (shiftRes),
    .carryRes (carryRes),
    .crRes    (crRes)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outValid <= 1'b0;
          result   <= '0;
          carryOut <= 1'b0;
          crValid  <= 1'b0;
          crOut    <= 4'b0000;
        end else begin
          outValid <= inValid;
          result   <= shiftRes;
          carryOut <= carryRes;
          crValid  <= inValid & record;
          crOut    <= crRes;
        end
      end
    end else begin : g_comb
      assign outValid = inValid;
      assign result   = shiftRes;
      assign carryOut = carryRes;
      assign crValid  = inValid & record;
      assign crOut    = crRes;
    end
  endgenerate

endmodule

// File: rtl/word_shifter_chk.sv
module word_shifter_chk #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic [1:0]             kind,
  input logic                   useImm,
  input logic [W-1:0]           srcA,
  input logic [W-1:0]           srcB,
  input logic [$clog2(W)-1:0]   immCnt,
  input logic                   record,
  input logic                   soIn,
  input logic                   carryIn,
  input logic                   outValid,
  input logic [W-1:0]           result,
  input logic                   carryOut,
  input logic                   crValid,
  input logic [3:0]             crOut
);
  localparam int IMM_W = $clog2(W);
  localparam int CNT_W = IMM_W + 1;

  logic             dValid, dUseImm, dCarry, dRec, dSo;
  logic [1:0]       dKind;
  logic [W-1:0]     dA, dB;
  logic [IMM_W-1:0] dImm;

  generate
    if (OUT_REG) begin : g_mir
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dValid <= 1'b0; dUseImm <= 1'b0; dCarry <= 1'b0; dRec <= 1'b0;
          dSo <= 1'b0; dKind <= 2'b00; dA <= '0; dB <= '0; dImm <= '0;
        end else begin
          dValid <= inValid; dUseImm <= useImm; dCarry <= carryIn;
          dRec <= record; dSo <= soIn; dKind <= kind; dA <= srcA;
          dB <= srcB; dImm <= immCnt;
        end
      end
    end else begin : g_mir
      assign dValid = inValid; assign dUseImm = useImm; assign dCarry = carryIn;
      assign dRec = record; assign dSo = soIn; assign dKind = kind;
      assign dA = srcA; assign dB = srcB; assign dImm = immCnt;
    end
  endgenerate

  logic satCnt, zeroCnt;
  assign satCnt  = ~dUseImm & dB[CNT_W-1];
  assign zeroCnt = dUseImm ? (dImm == '0) : (dB[CNT_W-1:0] == '0);

  AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    outValid == dValid); // R11

  AST_CR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> crValid == dRec); // R10

  AST_CR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    crValid |-> ($countones(crOut[3:1]) == 1 && crOut[0] == dSo)); // R10

  AST_CR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !dRec) |-> crOut == 4'b0000); // R10

  AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !dKind[1]) |-> carryOut == dCarry); // R8

  AST_FULL_LOGIC: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !dKind[1] && satCnt) |-> result == '0); // R5

  AST_FULL_ARITH: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && dKind[1] && satCnt) |-> result == {W{dA[W-1]}}); // R5

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && zeroCnt) |-> result == dA); // R9

  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && dKind[1]) |-> result[W-1] == dA[W-1]); // R3

  AST_POS_NOCARRY: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && dKind[1] && !dA[W-1]) |-> !carryOut); // R7

endmodule

bind word_shifter word_shifter_chk #(.W(W), .OUT_REG(OUT_REG)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .kind(kind), .useImm(useImm),
  .srcA(srcA), .srcB(srcB), .immCnt(immCnt), .record(record), .soIn(soIn),
  .carryIn(carryIn), .outValid(outValid), .result(result),
  .carryOut(carryOut), .crValid(crValid), .crOut(crOut)
);

// File: tb/test_word_shifter.sv
`timescale 1ns/1ps
module test_word_shifter;
  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [1:0] kind = 2'b00;
  logic       useImm = 1'b0;
  logic [7:0] srcA = '0, srcB = '0;
  logic [2:0] immCnt = '0;
  logic       record = 1'b0, soIn = 1'b0, carryIn = 1'b0;
  logic       outValid, carryOut, crValid;
  logic [7:0] result;
  logic [3:0] crOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  word_shifter #(.W(W), .OUT_REG(1'b1)) i_word_shifter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .kind(kind), .useImm(useImm),
    .srcA(srcA), .srcB(srcB), .immCnt(immCnt), .record(record), .soIn(soIn),
    .carryIn(carryIn), .outValid(outValid), .result(result),
    .carryOut(carryOut), .crValid(crValid), .crOut(crOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one vector at a falling edge, check it at the next falling edge
  task automatic runVec(input int k, input int a, input int b,
                        input bit imm, input int ic,
                        input bit rec, input bit so, input bit cin);
    int amt, sa, d, expRes, expCarry, sr;
    int expCr;
    kind = 2'(k); srcA = 8'(a); srcB = 8'(b); useImm = imm;
    immCnt = 3'(ic); record = rec; soIn = so; carryIn = cin; inValid = 1'b1;
    if (imm) amt = ic;                      // R6
    else if ((b % 16) >= 8) amt = 8;        // R5
    else amt = b % 8;                       // R4
    d = 1 << amt;
    sa = (a >= 128) ? a - 256 : a;
    if (k == 0) begin
      expRes = (a * d) % 256;               // R1
      expCarry = cin;                       // R8
    end else if (k == 1) begin
      expRes = a / d;                       // R2
      expCarry = cin;                       // R8
    end else begin
      if (sa >= 0) sr = sa / d; else sr = -((-sa + d - 1) / d);
      expRes = (sr + 256) % 256;            // R3
      expCarry = (sa < 0 && (a % d) != 0) ? 1 : 0; // R7
    end
    sr = (expRes >= 128) ? expRes - 256 : expRes;
    expCr = rec ? ((sr < 0) * 8 + (sr > 0) * 4 + (sr == 0) * 2 + so) : 0;
    @(negedge clk);
    chk("R11 outValid", int'(outValid), 1);
    chk(amt == 0 ? "R9 result" : (amt == 8 ? "R5 result" : "R1/R2/R3 result"),
        int'(result), expRes);
    chk(k >= 2 ? "R7 carryOut" : "R8 carryOut", int'(carryOut), expCarry);
    chk("R10 crOut", int'(crOut), expCr);
    chk("R10 crValid", int'(crValid), int'(rec));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset outValid", int'(outValid), 0);
    chk("R11 reset result", int'(result), 0);
    chk("R11 reset carryOut", int'(carryOut), 0);
    chk("R11 reset crOut", int'(crOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    // Register counts: every kind code, operand and 4-bit count field.
    // Upper bits of srcB carry garbage (R4).
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 16; c++)
          runVec(k, a, (((a ^ 8'h5A) & 8'hF0) | c), 1'b0, (a + c) % 8,
                 a[0] ^ c[0], a[1], c[1] ^ a[2]);
    // Immediate counts with srcB forced to saturating garbage (R6)
    for (int k = 0; k < 3; k++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 8; c++)
          runVec(k, a, 8'hF8 ^ (a & 8'h30), 1'b1, c,
                 a[3] ^ c[0], c[2], a[0]);
    // Idle cycle: outValid drops one clock later (R11)
    inValid = 1'b0;
    @(negedge clk);
    chk("R11 idle outValid", int'(outValid), 0);
    chk("R10 idle crValid", int'(crValid), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule